// File: doc/BRIEF.md
# SPI Master Continuous Receive Sequencer

This block is the receive-only half of an SPI master. It runs back-to-back frames while its enable input is high. Each frame pulls chip select low, waits a lead delay, and then drives a frame of 1 to 32 SCK periods. On each rising SCK edge it samples one data bit. The frame then waits a trail delay, raises chip select, and holds it high for at least a minimum idle gap before the next frame can begin.

Each completed word goes into a small receive FIFO, and the block reports the FIFO fill level. A new frame begins only when the FIFO has room, so received data is never lost. When the fill level moves from empty to one entry, the block pulses either an interrupt line or a DMA request line. A second interrupt pulses once per frame, at the moment chip select rises.

All delays and the SCK half-period come from static configuration inputs and are counted in system clock cycles. A configured value of 0 acts as 1.

Top module: `spi_rx_seq`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, level_o is 0, and fifo_irq_o, dma_req_o and done_irq_o are 0.
- R2: sck_o is 0 whenever cs_no is 1. The frame behaves as follows:
  - Once cs_no falls, sck_o stays 0 for max(lead_i,1) cycles plus max(half_i,1) cycles.
  - sck_o then alternates between high and low phases, each max(half_i,1) cycles long.
  - The frame has exactly len_i+1 high phases.
- R3: miso_i is sampled at each rising SCK edge, first bit most significant. The word is right-aligned in rd_data_o: the first bit sits at bit position len_i, and the upper bits are 0. The word is stored in the same clock edge as the last rising SCK edge. rd_data_o shows the oldest stored word whenever level_o is nonzero.
- R4: Start and end of chip select:
  - cs_no falls in the cycle after the block decides to start a frame.
  - cs_no rises max(trail_i,1) cycles after the last SCK high phase ends.
- R5: level_o rises by one on each stored word. A one-cycle rd_i while level_o is nonzero drops the oldest word and lowers level_o by one. A one-cycle rd_i while level_o is 0 leaves level_o at 0.
- R6: When level_o goes from 0 to 1, one pulse of one cycle appears in the same cycle:
  - on fifo_irq_o if use_dma_i is 0;
  - on dma_req_o if use_dma_i is 1.
- R7: done_irq_o is a one-cycle pulse in the first cycle that cs_no is high after each frame.
- R8: After a frame, cs_no stays high for at least max(gap_i,1) cycles. A new frame then starts only if en_i is 1 and the FIFO is not full. Otherwise the block waits with cs_no high and starts in the cycle after both conditions hold.
- R9: Clearing en_i in the middle of a frame does not cut it short. The frame completes through its trail delay and stores its word, and no further frame starts.
- R10: A value of 0 on lead_i, trail_i, gap_i or half_i behaves exactly like a value of 1.
- R11: A word is never written into a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run continuous frames while high |
| len_i | input | LEN_W (5) | Frame length minus one, in bits |
| half_i | input | DLY_W (8) | SCK half-period in clock cycles |
| lead_i | input | DLY_W (8) | Delay from chip select low to the first SCK phase |
| trail_i | input | DLY_W (8) | Delay from the end of the last SCK high phase to chip select high |
| gap_i | input | DLY_W (8) | Minimum time chip select stays high between frames |
| use_dma_i | input | 1 | Route the level event to dma_req_o instead of fifo_irq_o |
| miso_i | input | 1 | Serial data in |
| rd_i | input | 1 | Pop the oldest FIFO word |
| sck_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| rd_data_o | output | MAX_BITS (32) | Oldest stored word |
| level_o | output | LVL_W (1) | FIFO fill level |
| fifo_irq_o | output | 1 | Pulse when the level moves from 0 to 1 (interrupt route) |
| dma_req_o | output | 1 | Pulse when the level moves from 0 to 1 (DMA route) |
| done_irq_o | output | 1 | Pulse at the end of each frame |

## Verification
Two events can land in the same clock cycle: a FIFO pop from rd_i, and the decision to start the next frame when the idle gap expires. The start decision uses the registered fill level. A pop in that exact cycle therefore delays the start by one cycle rather than enabling it at once. The bench provokes this with a pseudo-random read strobe while one-entry frames run with minimal delays, so pops fall on every phase of the sequence. A behavioural model advances in step with the design and judges chip select, SCK, level, data and both interrupt routes on every cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_TRAIL = 3'd4,
    ST_GAP   = 3'd5
  } rx_state_e;
endpackage

// File: rtl/spi_rx_dly.sv
module spi_rx_dly #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] lim;

  // zero acts as one cycle
  assign lim    = (dly_i == '0) ? '0 : dly_i - 1'b1;
  assign done_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  a_r10_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int MAX_BITS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                sample_i,
  input  logic                miso_i,
  output logic [MAX_BITS-1:0] word_o
);
  logic [MAX_BITS-1:0] sh_q;

  assign word_o = {sh_q[MAX_BITS-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (clr_i)    sh_q <= '0;
    else if (sample_i) sh_q <= word_o;
  end

  a_r3_no_sample_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !sample_i);
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             do_pop;

  assign do_pop  = pop_i && (lvl_q != '0);
  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_q + LVL_W'(push_i) - LVL_W'(do_pop);
  end

  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] d_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     d_q <= '0;
        else if (push_i) d_q <= wdata_i;
      end
      assign rdata_o = d_q;
    end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      logic [W-1:0]     mem_q [DEPTH];
      logic [PTR_W-1:0] wp_q, rp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wp_q <= '0;
          rp_q <= '0;
        end else begin
          if (push_i) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
          if (do_pop) rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
        end
      end
      always_ff @(posedge clk_i) begin
        if (push_i) mem_q[wp_q] <= wdata_i;
      end
      assign rdata_o = mem_q[rp_q];
    end
  endgenerate

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r5_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && do_pop) |=> (lvl_q == $past(lvl_q) - 1'b1));
endmodule

// File: rtl/spi_rx_seq.sv
module spi_rx_seq
  import spi_rx_pkg::*;
#(
  parameter int MAX_BITS   = 32,
  parameter int FIFO_DEPTH = 1,
  parameter int DLY_W      = 8,
  localparam int LEN_W = $clog2(MAX_BITS),
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [DLY_W-1:0]    half_i,
  input  logic [DLY_W-1:0]    lead_i,
  input  logic [DLY_W-1:0]    trail_i,
  input  logic [DLY_W-1:0]    gap_i,
  input  logic                use_dma_i,
  input  logic                miso_i,
  input  logic                rd_i,
  output logic                sck_o,
  output logic                cs_no,
  output logic [MAX_BITS-1:0] rd_data_o,
  output logic [LVL_W-1:0]    level_o,
  output logic                fifo_irq_o,
  output logic                dma_req_o,
  output logic                done_irq_o
);
  rx_state_e state_q, state_d;
  logic [DLY_W-1:0]    lim;
  logic                ph_done, ph_clr;
  logic [LEN_W-1:0]    bit_q;
  logic                last_q;
  logic                sample, push, full, start_ok, frame_start;
  logic [MAX_BITS-1:0] word;
  logic [LVL_W-1:0]    lvl;
  logic                rise_q_irq, rise_q_dma, done_q;

  assign start_ok    = en_i && !full;
  assign sample      = (state_q == ST_LOW) && ph_done;
  assign push        = sample && (bit_q == len_i);
  assign ph_clr      = (state_d != state_q);
  assign frame_start = (state_d == ST_LEAD) && (state_q != ST_LEAD);

  always_comb begin
    unique case (state_q)
      ST_LEAD:         lim = lead_i;
      ST_LOW, ST_HIGH: lim = half_i;
      ST_TRAIL:        lim = trail_i;
      ST_GAP:          lim = gap_i;
      default:         lim = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_LEAD;
      ST_LEAD:  if (ph_done)  state_d = ST_LOW;
      ST_LOW:   if (ph_done)  state_d = ST_HIGH;
      ST_HIGH:  if (ph_done)  state_d = last_q ? ST_TRAIL : ST_LOW;
      ST_TRAIL: if (ph_done)  state_d = ST_GAP;
      ST_GAP:   if (ph_done)  state_d = start_ok ? ST_LEAD : ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (frame_start) begin
        bit_q  <= '0;
        last_q <= 1'b0;
      end else if (sample) begin
        bit_q <= bit_q + 1'b1;
        if (push) last_q <= 1'b1;
      end
    end
  end

  spi_rx_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ph_clr),
    .dly_i (lim),
    .done_o(ph_done)
  );

  spi_rx_shift #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (frame_start),
    .sample_i(sample),
    .miso_i  (miso_i),
    .word_o  (word)
  );

  spi_rx_fifo #(.W(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(word),
    .pop_i  (rd_i),
    .rdata_o(rd_data_o),
    .level_o(lvl),
    .full_o (full)
  );

  // level event: empty now, nonempty next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q_irq <= 1'b0;
      rise_q_dma <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      rise_q_irq <= (lvl == '0) && push && !use_dma_i;
      rise_q_dma <= (lvl == '0) && push &&  use_dma_i;
      done_q     <= (state_q == ST_TRAIL) && ph_done;
    end
  end

  assign level_o    = lvl;
  assign fifo_irq_o = rise_q_irq;
  assign dma_req_o  = rise_q_dma;
  assign done_irq_o = done_q;
  assign sck_o      = (state_q == ST_HIGH);
  assign cs_no      = (state_q == ST_IDLE) || (state_q == ST_GAP);

  a_r2_sck_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  a_r7_done_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> cs_no);
  a_r6_irq_on_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_irq_o || dma_req_o) |-> (lvl != '0));
  a_r6_routes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_irq_o && dma_req_o));
  a_r8_start_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD && $past(state_q) != ST_LEAD) |-> !$past(full));
endmodule

// File: tb/spi_rx_seq_tb_top.sv
module spi_rx_seq_tb_top;
  localparam int DEPTH = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, use_dma = 1'b0, miso = 1'b0, rd = 1'b0;
  logic [4:0]  len = '0;
  logic [7:0]  half = 8'd1, lead = 8'd1, trail = 8'd1, gap = 8'd1;
  logic        sck, cs_n, fifo_irq, dma_req, done_irq;
  logic [31:0] rd_data;
  logic [0:0]  level;

  always #5 clk = ~clk;

  spi_rx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .len_i(len), .half_i(half),
    .lead_i(lead), .trail_i(trail), .gap_i(gap), .use_dma_i(use_dma),
    .miso_i(miso), .rd_i(rd), .sck_o(sck), .cs_no(cs_n), .rd_data_o(rd_data),
    .level_o(level), .fifo_irq_o(fifo_irq), .dma_req_o(dma_req),
    .done_irq_o(done_irq)
  );

  int tests = 0, fails = 0, cyc = 0, frames = 0;
  int rd_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model
  int m_st = 0, m_cnt = 0, m_bits = 0;
  bit m_last = 0, m_irq = 0, m_dma = 0, m_done = 0;
  logic [31:0] m_sh = '0;
  logic [31:0] m_q[$];

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_bits = 0; m_last = 0; m_sh = '0;
      m_irq = 0; m_dma = 0; m_done = 0; m_q.delete();
    end else begin
      int lim, nst, old;
      bit dn, start, push;
      case (m_st)
        1: lim = lead;
        2, 3: lim = half;
        4: lim = trail;
        5: lim = gap;
        default: lim = 1;
      endcase
      dn = (m_cnt == eff(lim) - 1);
      start = en && (m_q.size() < DEPTH);
      nst = m_st; push = 0;
      case (m_st)
        0: if (start) nst = 1;
        1: if (dn) nst = 2;
        2: if (dn) begin
             nst = 3;
             m_sh = {m_sh[30:0], miso};
             if (m_bits == int'(len)) begin push = 1; m_last = 1; end
             m_bits++;
           end
        3: if (dn) nst = m_last ? 4 : 2;
        4: if (dn) nst = 5;
        5: if (dn) nst = start ? 1 : 0;
        default: nst = 0;
      endcase
      m_done = (m_st == 4) && dn;
      if (m_done) frames++;
      old = m_q.size();
      if (rd && old > 0) void'(m_q.pop_front());
      if (push) m_q.push_back(m_sh);
      m_irq = (old == 0) && (m_q.size() != 0) && !use_dma;
      m_dma = (old == 0) && (m_q.size() != 0) && use_dma;
      if (nst == 1 && m_st != 1) begin m_sh = '0; m_bits = 0; m_last = 0; end
      m_cnt = (nst != m_st) ? 0 : m_cnt + 1;
      m_st = nst;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cs_n == (m_st == 0 || m_st == 5), "R4", "cs_no", cs_n, (m_st == 0 || m_st == 5));
      chk(sck == (m_st == 3), "R2", "sck_o", sck, (m_st == 3));
      chk(int'(level) == m_q.size(), "R5", "level_o", level, m_q.size());
      if (m_q.size() > 0) chk(rd_data == m_q[0], "R3", "rd_data_o", rd_data, m_q[0]);
      chk(fifo_irq == m_irq, "R6", "fifo_irq_o", fifo_irq, m_irq);
      chk(dma_req == m_dma, "R6", "dma_req_o", dma_req, m_dma);
      chk(done_irq == m_done, "R7", "done_irq_o", done_irq, m_done);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[3];
    case (rd_mode)
      1: rd = lfsr[7] & lfsr[2];
      2: rd = level[0];
      default: ;
    endcase
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0;
    run(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_no after reset", cs_n, 1);
    chk(sck == 1'b0, "R1", "sck_o after reset", sck, 0);
    chk(level == '0, "R1", "level_o after reset", level, 0);
    chk({fifo_irq, dma_req, done_irq} == 3'b000, "R1", "irqs after reset",
        {fifo_irq, dma_req, done_irq}, 0);

    // 32-bit frames, no reads: stalls full (R8, R11)
    len = 5'd31; half = 8'd1; lead = 8'd2; trail = 8'd3; gap = 8'd4; en = 1'b1;
    run(300);
    chk(level == 1'b1 && cs_n == 1'b1, "R8", "stalled while full", {level, cs_n}, 2'b11);
    rd = 1'b1; run(1); rd = 1'b0;
    run(1);
    chk(cs_n == 1'b0, "R8", "restart after pop", cs_n, 0);

    // random reads, pops colliding with start decisions
    rd_mode = 1;
    run(1500);

    // R9: drop enable mid-frame
    t0 = 0;
    while (!(sck == 1'b1) && t0 < 2000) begin run(1); t0++; end
    t0 = frames;
    en = 1'b0;
    run(300);
    chk(frames == t0 + 1, "R9", "frame finished after disable", frames, t0 + 1);
    chk(cs_n == 1'b1, "R9", "idle after disable", cs_n, 1);

    // R5: read on empty
    rd_mode = 0; rd = 1'b1; run(3); rd = 1'b0; run(1);
    chk(level == '0, "R5", "drained", level, 0);
    rd = 1'b1; run(1); rd = 1'b0; run(1);
    chk(level == '0, "R5", "read on empty ignored", level, 0);

    // R10: zero delays, 8-bit frames, DMA route
    len = 5'd7; half = 8'd0; lead = 8'd0; trail = 8'd0; gap = 8'd0;
    use_dma = 1'b1; rd_mode = 1; en = 1'b1;
    run(1500);
    // same timing with explicit ones
    half = 8'd1; lead = 8'd1; trail = 8'd1; gap = 8'd1;
    run(800);

    // 1-bit frames, slow clock, immediate reads
    en = 1'b0; run(100);
    len = 5'd0; half = 8'd3; lead = 8'd5; trail = 8'd2; gap = 8'd6;
    use_dma = 1'b0; rd_mode = 2; en = 1'b1;
    run(1500);
    chk(frames > 20, "R7", "frames completed", frames, 21);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule